// File: doc/BRIEF.md
# Range-Return Shader Flow Sequencer

This block steers the program counter of a shader core through a 1024-word program store. Subroutine calls and two-armed conditional blocks are both reduced to one primitive: push a pair holding an end address and a return address onto a small stack. There is no return instruction. Before an instruction at the current address is executed, the sequencer compares that address with the end address on top of the stack. On a match it jumps to the stored return address and pops the entry. It spends that cycle on the jump alone and then checks again.

The instruction decoder supplies the flow opcode, the target offset, the instruction count and the index of a boolean uniform. A condition unit supplies one branch bit. The sequencer drives the fetch address, a halt flag and a sticky stack-overflow error. A start pulse loads an entry address, empties the stack and clears both flags.

Top module: `shader_flow_seq`

## Requirements
- R1: While reset is asserted, fetch_addr_o is 0, halt_o is 1 and overflow_o is 0.
- R2: A start_i pulse in one cycle makes fetch_addr_o equal entry_addr_i in the next cycle. It also deasserts halt_o and overflow_o and empties the stack. Start takes priority over every other event.
- R3: Opcode encoding on op_i is 0 no-op, 1 end, 2 call, 3 uniform-if and 4 condition-if. A no-op, and any code from 5 to 7, advances the fetch address by one.
- R4: A call with target D and count N at address P pushes the pair (end D+N, return P+1) and fetches D next. All address arithmetic wraps modulo 1024.
- R5: When the stack is not empty and the fetch address equals the top end address, the next fetch address is the top return address and the entry is popped. The opcode present in that cycle is ignored; an end code does not halt.
- R6: A uniform-if at P whose condition is true pushes (end D, return D+N) and fetches P+1. The then-block runs up to D, and the else-block from D to D+N is skipped.
- R7: A uniform-if whose condition is false pushes (end D+N, return D+N) and fetches D, so only the else-block runs.
- R8: A condition-if behaves as R6 and R7, but it takes its condition from cond_i and ignores the boolean uniforms.
- R9: The condition of a uniform-if is bit bidx_i of the 16-bit bool_uniforms_i.
- R10: An end opcode raises halt_o in the next cycle. After that, halt_o stays high and fetch_addr_o holds until the next start.
- R11: A push attempted when 8 entries are held raises overflow_o and halt_o, and the fetch address holds. Both stay high until the next start.
- R12: Entries that share an end address pop one per cycle in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse: load entry address, clear stack and flags |
| entry_addr_i | input | 10 | Program entry address |
| op_i | input | 3 | Decoded flow opcode of the instruction at fetch_addr_o |
| dst_i | input | 10 | Target offset D |
| cnt_i | input | 8 | Instruction count N |
| bidx_i | input | 4 | Boolean uniform index |
| bool_uniforms_i | input | 16 | Boolean uniform registers |
| cond_i | input | 1 | Branch bit from the condition unit |
| fetch_addr_o | output | 10 | Program counter / fetch address |
| halt_o | output | 1 | Sequencer stopped |
| overflow_o | output | 1 | Sticky stack-overflow error |

## Verification
The bench builds the block with its default parameters: a 10-bit address, an 8-bit count, 8 stack entries and 16 boolean uniforms. Nine nested calls are therefore enough to reach the overflow path. With the full address width, the bench can place the then-arm, the else-arm and subroutine bodies far apart and plant end codes at addresses that only a wrong branch or an unsuppressed pop cycle would execute. Zero-length calls and ifs that share their end with an enclosing call drive the back-to-back pop corner.

// File: rtl/shader_flow_pkg.sv
package shader_flow_pkg;
   typedef enum logic [2:0] {
      FOP_NOP  = 3'd0,
      FOP_END  = 3'd1,
      FOP_CALL = 3'd2,
      FOP_IFU  = 3'd3,
      FOP_IFC  = 3'd4
   } flow_op_e;
endpackage

// File: rtl/flow_range_stack.sv
module flow_range_stack #(
   parameter int ADDR_W = 10,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic [ADDR_W-1:0] push_end_i,
   input  logic [ADDR_W-1:0] push_ret_i,
   output logic [ADDR_W-1:0] top_end_o,
   output logic [ADDR_W-1:0] top_ret_o,
   output logic              empty_o,
   output logic              full_o
);
   localparam int PTR_W = $clog2(DEPTH + 1);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [PTR_W-1:0]    cnt_q;
   logic [2*ADDR_W-1:0] slot_q [DEPTH];
   logic [IDX_W-1:0]    top_idx;

   always_comb top_idx = IDX_W'(cnt_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (clr_i)              cnt_q <= '0;
      else if (push_i && !full_o)  cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !empty_o)  cnt_q <= cnt_q - 1'b1;
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (!clr_i && push_i && cnt_q == PTR_W'(i))
            slot_q[i] <= {push_end_i, push_ret_i};
      end
   end

   always_comb begin
      empty_o   = (cnt_q == '0);
      full_o    = (cnt_q == PTR_W'(DEPTH));
      top_end_o = slot_q[top_idx][2*ADDR_W-1:ADDR_W];
      top_ret_o = slot_q[top_idx][ADDR_W-1:0];
   end
endmodule

// File: rtl/flow_step.sv
module flow_step
   import shader_flow_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int CNT_W  = 8
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [2:0]        op_i,
   input  logic [ADDR_W-1:0] dst_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              take_i,
   output logic [ADDR_W-1:0] next_o,
   output logic              push_o,
   output logic [ADDR_W-1:0] push_end_o,
   output logic [ADDR_W-1:0] push_ret_o,
   output logic              halt_o
);
   logic [ADDR_W-1:0] seq_pc;
   logic [ADDR_W-1:0] span_end;

   always_comb begin
      seq_pc     = pc_i + 1'b1;
      span_end   = dst_i + ADDR_W'(cnt_i);
      next_o     = seq_pc;
      push_o     = 1'b0;
      push_end_o = span_end;
      push_ret_o = span_end;
      halt_o     = 1'b0;
      case (flow_op_e'(op_i))
         FOP_END:  halt_o = 1'b1;
         FOP_CALL: begin
            push_o     = 1'b1;
            push_ret_o = seq_pc;
            next_o     = dst_i;
         end
         FOP_IFU, FOP_IFC: begin
            push_o = 1'b1;
            if (take_i) begin
               push_end_o = dst_i;
               next_o     = seq_pc;
            end else begin
               next_o     = dst_i;
            end
         end
         default: next_o = seq_pc;
      endcase
   end
endmodule

// File: rtl/shader_flow_seq.sv
module shader_flow_seq
   import shader_flow_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int CNT_W    = 8,
   parameter int DEPTH    = 8,
   parameter int NUM_BOOL = 16,
   localparam int BIDX_W  = (NUM_BOOL > 1) ? $clog2(NUM_BOOL) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [ADDR_W-1:0]   entry_addr_i,
   input  logic [2:0]          op_i,
   input  logic [ADDR_W-1:0]   dst_i,
   input  logic [CNT_W-1:0]    cnt_i,
   input  logic [BIDX_W-1:0]   bidx_i,
   input  logic [NUM_BOOL-1:0] bool_uniforms_i,
   input  logic                cond_i,
   output logic [ADDR_W-1:0]   fetch_addr_o,
   output logic                halt_o,
   output logic                overflow_o
);
   if (DEPTH < 2)        begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (CNT_W > ADDR_W)   begin : g_bad_cnt   $error("CNT_W must not exceed ADDR_W"); end
   if (ADDR_W < 2)       begin : g_bad_addr  $error("ADDR_W must be at least 2"); end

   logic [ADDR_W-1:0] pc_q;
   logic              halted_q;
   logic              ovf_q;

   logic [ADDR_W-1:0] stk_top_end, stk_top_ret;
   logic              stk_empty, stk_full;
   logic              pop_hit, do_push, do_pop;

   logic [ADDR_W-1:0] step_next, step_end, step_ret;
   logic              step_push, step_halt;
   logic              uni_bit, take_bit;

   if (NUM_BOOL == 1) begin : g_uni_single
      assign uni_bit = bool_uniforms_i[0];
   end else begin : g_uni_index
      assign uni_bit = bool_uniforms_i[bidx_i];
   end

   assign take_bit = (op_i == FOP_IFC) ? cond_i : uni_bit;

   flow_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) step_i (
      .pc_i       (pc_q),
      .op_i       (op_i),
      .dst_i      (dst_i),
      .cnt_i      (cnt_i),
      .take_i     (take_bit),
      .next_o     (step_next),
      .push_o     (step_push),
      .push_end_o (step_end),
      .push_ret_o (step_ret),
      .halt_o     (step_halt)
   );

   always_comb begin
      pop_hit = !halted_q && !stk_empty && (stk_top_end == pc_q);
      do_pop  = !start_i && pop_hit;
      do_push = !start_i && !halted_q && !pop_hit && step_push && !stk_full;
   end

   flow_range_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) stack_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (start_i),
      .push_i     (do_push),
      .pop_i      (do_pop),
      .push_end_i (step_end),
      .push_ret_i (step_ret),
      .top_end_o  (stk_top_end),
      .top_ret_o  (stk_top_ret),
      .empty_o    (stk_empty),
      .full_o     (stk_full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= '0;
         halted_q <= 1'b1;
         ovf_q    <= 1'b0;
      end else if (start_i) begin
         pc_q     <= entry_addr_i;
         halted_q <= 1'b0;
         ovf_q    <= 1'b0;
      end else if (!halted_q) begin
         if (pop_hit) begin
            pc_q <= stk_top_ret;
         end else if (step_halt) begin
            halted_q <= 1'b1;
         end else if (step_push && stk_full) begin
            ovf_q    <= 1'b1;
            halted_q <= 1'b1;
         end else begin
            pc_q <= step_next;
         end
      end
   end

   assign fetch_addr_o = pc_q;
   assign halt_o       = halted_q;
   assign overflow_o   = ovf_q;
endmodule

// File: rtl/shader_flow_seq_chk.sv
module shader_flow_seq_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic [ADDR_W-1:0] entry_addr_i,
   input logic [2:0]        op_i,
   input logic [ADDR_W-1:0] dst_i,
   input logic [ADDR_W-1:0] fetch_addr_o,
   input logic              halt_o,
   input logic              overflow_o,
   input logic              pop_hit,
   input logic              stk_full
);
   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!halt_o && !overflow_o && fetch_addr_o == $past(entry_addr_i)));

   // R3
   nop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !halt_o && !pop_hit && op_i == 3'd0)
      |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1);

   // R4
   call_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !halt_o && !pop_hit && !stk_full && op_i == 3'd2)
      |=> fetch_addr_o == $past(dst_i));

   // R5
   pop_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && pop_hit) |=> !halt_o);

   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_o && !start_i) |=> (halt_o && $stable(fetch_addr_o)));

   // R11
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow_o && !start_i) |=> overflow_o);

   // R11
   ovf_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |-> halt_o);
endmodule

bind shader_flow_seq shader_flow_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .entry_addr_i (entry_addr_i),
   .op_i         (op_i),
   .dst_i        (dst_i),
   .fetch_addr_o (fetch_addr_o),
   .halt_o       (halt_o),
   .overflow_o   (overflow_o),
   .pop_hit      (pop_hit),
   .stk_full     (stk_full)
);

// File: tb/shader_flow_seq_tb_top.sv
module shader_flow_seq_tb_top;
   localparam int AW = 10;
   localparam int MEMN = 1024;
   localparam int MASK = MEMN - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [9:0]  entry = '0;
   logic [15:0] uni = '0;
   logic        cond = 1'b0;
   logic [9:0]  fetch;
   logic        halt, ovf;
   logic [2:0]  op;
   logic [9:0]  dst;
   logic [7:0]  cnt;
   logic [3:0]  bidx;

   logic [2:0] m_op   [MEMN];
   logic [9:0] m_dst  [MEMN];
   logic [7:0] m_cnt  [MEMN];
   logic [3:0] m_bidx [MEMN];

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   assign op   = m_op[fetch];
   assign dst  = m_dst[fetch];
   assign cnt  = m_cnt[fetch];
   assign bidx = m_bidx[fetch];

   shader_flow_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .entry_addr_i(entry),
      .op_i(op), .dst_i(dst), .cnt_i(cnt), .bidx_i(bidx),
      .bool_uniforms_i(uni), .cond_i(cond),
      .fetch_addr_o(fetch), .halt_o(halt), .overflow_o(ovf)
   );

   // Reference model
   int    mpc = 0;
   bit    mhalt = 1'b1;
   bit    movf = 1'b0;
   int    q_end[$];
   int    q_ret[$];
   string mtag = "R1";

   task automatic model_push(int e, int r, int nxt);
      if (q_end.size() == 8) begin
         movf = 1'b1; mhalt = 1'b1; mtag = "R11";
      end else begin
         q_end.push_back(e & MASK); q_ret.push_back(r & MASK); mpc = nxt & MASK;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         mpc = 0; mhalt = 1'b1; movf = 1'b0; q_end.delete(); q_ret.delete(); mtag = "R1";
      end else if (start) begin
         mpc = entry; mhalt = 1'b0; movf = 1'b0; q_end.delete(); q_ret.delete(); mtag = "R2";
      end else if (!mhalt) begin
         if (q_end.size() > 0 && q_end[$] == mpc) begin
            mpc = q_ret[$];
            void'(q_end.pop_back()); void'(q_ret.pop_back());
            mtag = "R5/R12";
         end else begin
            int d, n, bt;
            d = m_dst[mpc]; n = m_cnt[mpc];
            case (m_op[mpc])
               3'd1: begin mhalt = 1'b1; mtag = "R10"; end
               3'd2: begin mtag = "R4"; model_push(d + n, mpc + 1, d); end
               3'd3, 3'd4: begin
                  bt = (m_op[mpc] == 3'd4) ? cond : uni[m_bidx[mpc]];
                  mtag = (m_op[mpc] == 3'd4) ? "R8" : (bt ? "R6/R9" : "R7/R9");
                  if (bt) model_push(d, d + n, mpc + 1);
                  else    model_push(d + n, d + n, d);
               end
               default: begin mpc = (mpc + 1) & MASK; mtag = "R3"; end
            endcase
         end
      end
   end

   always @(negedge clk) begin
      cycles++;
      checks++;
      if (int'(fetch) != mpc || halt != mhalt || ovf != movf) begin
         errors++;
         $display("FAIL %s: fetch=%0d halt=%0b ovf=%0b expected fetch=%0d halt=%0b ovf=%0b",
                  mtag, fetch, halt, ovf, mpc, mhalt, movf);
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < MEMN; i++) begin
         m_op[i] = 3'd0; m_dst[i] = '0; m_cnt[i] = '0; m_bidx[i] = '0;
      end
   endtask

   task automatic put(int a, int o, int d, int n, int b);
      m_op[a] = 3'(o); m_dst[a] = 10'(d); m_cnt[a] = 8'(n); m_bidx[a] = 4'(b);
   endtask

   task automatic launch(int a);
      @(negedge clk);
      start = 1'b1; entry = 10'(a);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_halt();
      for (int i = 0; i < 200 && !halt; i++) @(negedge clk);
   endtask

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      check("R1 fetch", int'(fetch), 0);
      check("R1 halt", int'(halt), 1);
      check("R1 ovf", int'(ovf), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R10 idle before start", int'(halt), 1);

      // Program A: call, both uniform-if arms, condition-if, unused code, end
      uni = 16'h0020;
      cond = 1'b1;
      put(0, 2, 20, 3, 0);
      put(1, 3, 5, 2, 5);
      put(5, 1, 0, 0, 0);
      put(7, 3, 10, 2, 6);
      put(12, 4, 15, 1, 6);
      put(16, 6, 0, 0, 0);
      put(17, 1, 0, 0, 0);
      launch(0);
      check("R2 start clears halt", int'(halt), 0);
      wait_halt();
      check("R10 halt at end", int'(fetch), 17);
      repeat (4) @(negedge clk);
      check("R10 halt held", int'(halt), 1);
      check("R10 fetch held", int'(fetch), 17);

      // Program B: zero-length call, shared end address, ends planted on pop cycles
      clear_mem();
      put(0, 2, 10, 5, 0);
      put(10, 2, 20, 0, 0);
      put(20, 1, 0, 0, 0);
      put(11, 3, 15, 0, 5);
      put(15, 1, 0, 0, 0);
      put(1, 1, 0, 0, 0);
      launch(0);
      wait_halt();
      check("R12 chained pops return", int'(fetch), 1);
      check("R5 no overflow", int'(ovf), 0);

      // Program C: nine nested calls
      clear_mem();
      for (int k = 0; k < 9; k++) put(k, 2, k + 1, 100, 0);
      launch(0);
      wait_halt();
      check("R11 overflow flag", int'(ovf), 1);
      check("R11 fetch holds", int'(fetch), 8);
      repeat (3) @(negedge clk);
      check("R11 sticky", int'(ovf), 1);

      // Program D: condition-if ignores uniforms
      clear_mem();
      uni = 16'hFFFF;
      cond = 1'b0;
      put(0, 4, 3, 2, 5);
      put(1, 1, 0, 0, 0);
      put(5, 1, 0, 0, 0);
      launch(0);
      check("R2 overflow cleared", int'(ovf), 0);
      wait_halt();
      check("R8 false arm reaches end", int'(fetch), 5);
      cond = 1'b1;
      put(1, 0, 0, 0, 0);
      put(3, 1, 0, 0, 0);
      launch(0);
      wait_halt();
      check("R8 true arm skips else", int'(fetch), 5);

      // Wrapping target arithmetic
      clear_mem();
      put(1020, 2, 1022, 4, 0);
      put(2, 1, 0, 0, 0);
      put(1021, 1, 0, 0, 0);
      launch(1020);
      wait_halt();
      check("R4 wrapped return", int'(fetch), 1021);

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20000 * 10);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule